// File: doc/BRIEF.md
# March C Memory Self-Test Engine with Live Fail Reporting

This block tests a 16-bit-wide synchronous single-port SRAM by running the March C algorithm against it without outside help. It drives the RAM's enable, write strobe, address and write data directly. It generates every write word and every expected read word itself. The data is a checkerboard, so each cell holds the opposite value of its neighbours in the row and in the column.

On each read, the engine registers the expected word and compares it with the RAM output one cycle later. Each comparison produces a live fail flag, qualified by a check strobe, together with the address and element index that the compared read belongs to. An external logger can therefore build a dynamic fail map as the test runs. Any failure also sets a sticky flag. That flag stays set after the run and is cleared only by the next start.

Top module: `mbist_marchc`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `sticky_fail`, `rd_check`, `fail_live` and `ram_en` are all 0.
- R2: A one-cycle `start` pulse sampled while the engine is idle or done begins a run. `busy` is then 1 from the next cycle. `done` rises exactly 10*2^AW + 1 clock edges after the edge that sampled `start`, and it stays 1 with `busy` at 0 until the next start.
- R3: The run applies six elements, numbered 0 to 5 on `fail_elem`:
  - Element 0: write polarity 0, ascending addresses.
  - Element 1: read polarity 0, then write polarity 1, ascending addresses.
  - Element 2: read polarity 1, then write polarity 0, ascending addresses.
  - Element 3: read polarity 0, then write polarity 1, descending addresses.
  - Element 4: read polarity 1, then write polarity 0, descending addresses.
  - Element 5: read polarity 0, descending addresses.
- R4: Bit i of a polarity-0 word at address A equals A[0] XOR (i mod 2). That is 16'hAAAA at even addresses and 16'h5555 at odd addresses. A polarity-1 word is the bitwise complement.
- R5: The engine issues exactly one RAM operation per cycle during a run, with no idle cycles. In a two-operation element, the write goes to the same address as the read that precedes it, in the next cycle.
- R6: `rd_check` is 1 in exactly the cycle after each read is issued, and 0 in every other cycle. In that cycle, `fail_addr` and `fail_elem` hold the address and element of that read.
- R7: `fail_live` is the OR of the 16 bitwise mismatches between `ram_rdata` and the expected word while `rd_check` is 1, and 0 otherwise.
- R8: `sticky_fail` becomes 1 after any cycle with `fail_live` at 1. It keeps that value through the end of the run and while done. It returns to 0 on the cycle after an accepted start.
- R9: `ram_en` is 0 whenever the engine is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a test run |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write strobe (1 = write, 0 = read) |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after a read |
| busy | output | 1 | Run or final compare in progress |
| done | output | 1 | Run finished; held until next start |
| rd_check | output | 1 | A read result is being compared this cycle |
| fail_live | output | 1 | The compared read mismatched |
| fail_addr | output | AW | Address of the compared read |
| fail_elem | output | 3 | Element index of the compared read |
| sticky_fail | output | 1 | Any mismatch since the last start |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read. They also assume that `start` is a single-cycle pulse raised only while the engine is idle or done. The bench keeps to both conditions. Its RAM model has a fixed one-cycle read register, and it pulses `start` only after `done` has been seen. Faults are injected only on the read path of the model, as stuck bits at a single address. The stored contents therefore stay correct, and the cycles in which the bench expects a mismatch follow from the requirements alone.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // Per-element attributes. A two-operation element always reads first and writes second.
  typedef struct packed {
    logic down;      // descending address order
    logic two_ops;   // read followed by write at each address
    logic first_rd;  // first (or only) operation is a read
    logic pol0;      // polarity of the first operation
    logic pol1;      // polarity of the second operation
  } elem_attr_t;

  localparam int unsigned NUM_ELEMS = 6;
  localparam int unsigned ELEM_W    = 3;

  function automatic elem_attr_t elem_attr(input logic [ELEM_W-1:0] e);
    elem_attr_t a;
    case (e)
      3'd0:    a = '{down: 1'b0, two_ops: 1'b0, first_rd: 1'b0, pol0: 1'b0, pol1: 1'b0};
      3'd1:    a = '{down: 1'b0, two_ops: 1'b1, first_rd: 1'b1, pol0: 1'b0, pol1: 1'b1};
      3'd2:    a = '{down: 1'b0, two_ops: 1'b1, first_rd: 1'b1, pol0: 1'b1, pol1: 1'b0};
      3'd3:    a = '{down: 1'b1, two_ops: 1'b1, first_rd: 1'b1, pol0: 1'b0, pol1: 1'b1};
      3'd4:    a = '{down: 1'b1, two_ops: 1'b1, first_rd: 1'b1, pol0: 1'b1, pol1: 1'b0};
      default: a = '{down: 1'b1, two_ops: 1'b0, first_rd: 1'b1, pol0: 1'b0, pol1: 1'b0};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/mbist_rst_sync.sv
module mbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mbist_datagen.sv
module mbist_datagen #(
  parameter int unsigned DW = 16
) (
  input  logic          addr_lsb,
  input  logic          pol,
  output logic [DW-1:0] word
);
  // Checkerboard: alternate by bit column and by address row, flip for polarity 1.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam logic COL_ODD = ((i % 2) == 1);
    assign word[i] = addr_lsb ^ COL_ODD ^ pol;
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              launch,
  output logic              issue,
  output logic              is_write,
  output logic              pol,
  output logic [AW-1:0]     addr,
  output logic [ELEM_W-1:0] elem,
  output logic              busy,
  output logic              done
);
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEMS - 1);
  localparam logic [AW-1:0]     ADDR_MAX  = {AW{1'b1}};

  seq_state_e        state_q, state_d;
  logic [ELEM_W-1:0] elem_q, elem_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              op_q, op_d;
  elem_attr_t        attr, next_attr;
  logic              at_end;
  logic              idle_like;

  assign attr      = elem_attr(elem_q);
  assign next_attr = elem_attr(elem_q + 1'b1);
  assign at_end    = attr.down ? (addr_q == '0) : (addr_q == ADDR_MAX);
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign launch    = start && idle_like;

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    addr_d  = addr_q;
    op_d    = op_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_RUN;
          elem_d  = '0;
          addr_d  = '0;
          op_d    = 1'b0;
        end
      end
      ST_RUN: begin
        if (attr.two_ops && !op_q) begin
          op_d = 1'b1;
        end else begin
          op_d = 1'b0;
          if (at_end) begin
            if (elem_q == LAST_ELEM) begin
              state_d = ST_DRAIN;
            end else begin
              elem_d = elem_q + 1'b1;
              addr_d = next_attr.down ? ADDR_MAX : '0;
            end
          end else begin
            addr_d = attr.down ? (addr_q - 1'b1) : (addr_q + 1'b1);
          end
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      addr_q  <= '0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      addr_q  <= addr_d;
      op_q    <= op_d;
    end
  end

  assign issue    = (state_q == ST_RUN);
  assign is_write = op_q ? 1'b1 : !attr.first_rd;
  assign pol      = op_q ? attr.pol1 : attr.pol0;
  assign addr     = addr_q;
  assign elem     = elem_q;
  assign busy     = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done     = (state_q == ST_DONE);

  // R2: an accepted start makes the engine busy next cycle
  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  // R3: element index never leaves the six-element range during a run
  a_r3_elem_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (elem_q <= LAST_ELEM));
  // R5: the write of a read/write pair targets the address just read
  a_r5_pair_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_q) |-> (addr_q == $past(addr_q)));
  // R9: no RAM activity once finished
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !issue);
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [AW-1:0]     rd_addr,
  input  logic [ELEM_W-1:0] rd_elem,
  input  logic [DW-1:0]     rd_exp,
  input  logic [DW-1:0]     rdata,
  output logic              rd_check,
  output logic              fail_live,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem,
  output logic              sticky
);
  logic              pend_q;
  logic [AW-1:0]     addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic [DW-1:0]     exp_q;
  logic              sticky_q, sticky_d;
  logic [DW-1:0]     bit_miss;

  // Pending-read strobe, aligned to the one-cycle RAM read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= rd_issue;
  end

  // Captured context of the read in flight, loaded only when a read is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      elem_q <= '0;
      exp_q  <= '0;
    end else if (rd_issue) begin
      addr_q <= rd_addr;
      elem_q <= rd_elem;
      exp_q  <= rd_exp;
    end
  end

  assign bit_miss  = rdata ^ exp_q;
  assign fail_live = pend_q && (|bit_miss);

  always_comb begin
    sticky_d = sticky_q;
    if (clear)          sticky_d = 1'b0;
    else if (fail_live) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign rd_check  = pend_q;
  assign fail_addr = addr_q;
  assign fail_elem = elem_q;
  assign sticky    = sticky_q;

  // R6: a compare cycle always follows a read issue
  a_r6_check_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_check |-> $past(rd_issue));
  // R7: a live failure is recorded in the sticky flag
  a_r7_fail_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_live && !clear) |=> sticky);
  // R8: the sticky flag holds until an accepted start
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clear) |=> sticky);
  // R8: an accepted start clears the sticky flag
  a_r8_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !sticky);
endmodule

// File: rtl/mbist_marchc.sv
module mbist_marchc
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              rd_check,
  output logic              fail_live,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem,
  output logic              sticky_fail
);
  logic              rst_n_s;
  logic              launch;
  logic              issue;
  logic              is_write;
  logic              pol;
  logic [AW-1:0]     addr;
  logic [ELEM_W-1:0] elem;
  logic [DW-1:0]     pattern;

  mbist_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mbist_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .launch   (launch),
    .issue    (issue),
    .is_write (is_write),
    .pol      (pol),
    .addr     (addr),
    .elem     (elem),
    .busy     (busy),
    .done     (done)
  );

  mbist_datagen #(.DW(DW)) u_gen (
    .addr_lsb (addr[0]),
    .pol      (pol),
    .word     (pattern)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear     (launch),
    .rd_issue  (issue && !is_write),
    .rd_addr   (addr),
    .rd_elem   (elem),
    .rd_exp    (pattern),
    .rdata     (ram_rdata),
    .rd_check  (rd_check),
    .fail_live (fail_live),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .sticky    (sticky_fail)
  );

  assign ram_en    = issue;
  assign ram_we    = issue && is_write;
  assign ram_addr  = addr;
  assign ram_wdata = pattern;

  // R1: nothing is active while the synchronised reset is low
  always_comb begin
    if (!rst_n_s) begin
      a_r1_reset_quiet: assert (!ram_en && !busy && !done && !sticky_fail);
    end
  end
endmodule

// File: tb/mbist_marchc_test.sv
module mbist_marchc_test;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;
  localparam int unsigned N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic          busy, done, rd_check, fail_live, sticky_fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Fault injection on the read path only
  logic          f_on = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;
  logic [DW-1:0] f_val = '0;
  logic [DW-1:0] mem [N];

  always #10 clk = ~clk;

  mbist_marchc #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .rd_check(rd_check), .fail_live(fail_live),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .sticky_fail(sticky_fail)
  );

  always @(posedge clk) begin
    if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_en && !ram_we) begin
      if (f_on && ram_addr == f_addr) ram_rdata <= (mem[ram_addr] & ~f_mask) | (f_val & f_mask);
      else                            ram_rdata <= mem[ram_addr];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input bit p);
    logic [DW-1:0] w;
    w = a[0] ? 16'h5555 : 16'hAAAA;
    return p ? ~w : w;
  endfunction

  // Expected operation k of a run, from the March C element list (R3)
  task automatic exp_op(input int k, output int e, output bit we,
                        output logic [AW-1:0] a, output bit p);
    int idx, sub, r;
    sub = 0;
    if (k < N) begin
      e = 0; idx = k;
    end else begin
      r = k - N;
      if (r < 8 * N) begin
        e = 1 + r / (2 * N); idx = (r % (2 * N)) / 2; sub = r % 2;
      end else begin
        e = 5; idx = r - 8 * N;
      end
    end
    a  = (e >= 3) ? AW'(N - 1 - idx) : AW'(idx);
    we = (e == 0) ? 1'b1 : (e == 5) ? 1'b0 : bit'(sub);
    case (e)
      1, 3:    p = bit'(sub);
      2, 4:    p = !bit'(sub);
      default: p = 1'b0;
    endcase
  endtask

  task automatic run(input bit fon, input logic [AW-1:0] fa,
                     input logic [DW-1:0] fm, input logic [DW-1:0] fv);
    bit              prev_rd;
    logic [AW-1:0]   prev_a;
    int              prev_e;
    bit              prev_fail;
    bit              any_fail;
    int              e;
    bit              we, p;
    logic [AW-1:0]   a;
    f_on = fon; f_addr = fa; f_mask = fm; f_val = fv;
    prev_rd = 0; prev_a = '0; prev_e = 0; prev_fail = 0; any_fail = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done, "R2", "busy after start", {busy, done}, 2'b10);
    check(!sticky_fail, "R8", "sticky cleared by start", sticky_fail, 0);
    for (int k = 0; k < 10 * N; k++) begin
      if (k > 0) @(negedge clk);
      exp_op(k, e, we, a, p);
      // R3 R4 R5: one operation per cycle, right order, address and data
      check(ram_en && ram_we == we && ram_addr == a && (!we || ram_wdata == pat(a, p)),
            "R3", $sformatf("op %0d", k), {ram_en, ram_we, ram_addr, ram_wdata},
            {1'b1, we, a, we ? pat(a, p) : ram_wdata});
      // R6 R7: compare result of the previous operation
      if (prev_rd)
        check(rd_check && fail_live == prev_fail && fail_addr == prev_a && fail_elem == 3'(prev_e),
              "R7", $sformatf("compare before op %0d", k), {rd_check, fail_live, fail_addr, fail_elem},
              {1'b1, prev_fail, prev_a, 3'(prev_e)});
      else
        check(!rd_check && !fail_live, "R6", $sformatf("no compare before op %0d", k),
              {rd_check, fail_live}, 0);
      prev_rd = !we; prev_a = a; prev_e = e;
      prev_fail = !we && fon && a == fa && ((pat(a, p) & fm) != (fv & fm));
      any_fail = any_fail || prev_fail;
    end
    @(negedge clk);
    check(rd_check && fail_live == prev_fail && fail_addr == prev_a && !ram_en && !done,
          "R6", "final compare", {rd_check, fail_live, fail_addr, ram_en, done},
          {1'b1, prev_fail, prev_a, 2'b00});
    @(negedge clk);
    check(done && !busy && !ram_en, "R2", "done after 10N+1 edges", {done, busy, ram_en}, 3'b100);
    check(sticky_fail == any_fail, "R8", "sticky at done", sticky_fail, any_fail);
    repeat (3) @(negedge clk);
    check(done && !ram_en && !rd_check && sticky_fail == any_fail, "R9", "done held, quiet",
          {done, ram_en, rd_check, sticky_fail}, {3'b100, any_fail});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!busy && !done && !sticky_fail && !ram_en && !rd_check && !fail_live, "R1", "in reset",
          {busy, done, sticky_fail, ram_en, rd_check}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !sticky_fail && !ram_en && !rd_check, "R1", "after release",
          {busy, done, sticky_fail, ram_en, rd_check}, 0);
    run(1'b0, '0, '0, '0);                       // clean memory
    run(1'b1, 4'd5, 16'h0008, 16'h0008);         // bit 3 stuck high at odd address
    run(1'b0, '0, '0, '0);                       // clean again: sticky must clear
    run(1'b1, 4'd10, 16'h0001, 16'h0000);        // bit 0 stuck low at even address
    run(1'b1, 4'd15, 16'hFFFF, 16'h1234);        // many bits wrong at last address
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule